// File: doc/BRIEF.md
# Mode-Banked General Register File

This block holds the sixteen-entry, 32-bit general register view of a processor that runs in several privilege modes. The stack pointer (register 13), the link register (register 14) and the saved status word are duplicated for each exception mode. A fast-interrupt mode also keeps its own copy of registers 8 to 12. When a mode-change request selects a mode whose bank differs from the current one, every affected register is exchanged with its stored copy on a single clock edge. The live register array then always shows the view of the current mode.

Two combinational read ports and one write port serve the datapath. Register 15 is not stored here: reads of index 15 return the program counter supplied from outside. A separate write port updates the active saved status word. The current mode code is brought out so that the surrounding core can track it. Reset clears every live register, every banked copy and every saved status word, and sets the mode to system.

Top module: `banked_regfile`

## Requirements
- R1: After reset, registers 0 to 14, every banked copy and every saved status word read zero, and the mode output is system (5'b11111).
- R2: Mode codes map to banks as follows. User 5'b10000 and system 5'b11111 use the unbanked set. Fast interrupt 5'b10001, interrupt 5'b10010, supervisor 5'b10011, abort 5'b10111 and undefined 5'b11011 each have a bank of their own. Any other code uses the unbanked set.
- R3: A mode request whose code equals the current mode changes nothing: the mode, the registers and the saved status stay as they are.
- R4: On a change between modes of different banks, the live registers 13 and 14 go into the old bank and the new bank's copies are loaded, on the same edge that updates the mode output.
- R5: Entering or leaving fast-interrupt mode also exchanges registers 8 to 12 between the fast-interrupt copy and one shared copy. Other bank changes leave registers 8 to 12 untouched.
- R6: On each bank change, the active saved status word is stored into the old bank and reloaded from the new bank.
- R7: A change between modes that share a bank (for example system to user, or to an unknown code) updates only the mode output.
- R8: A register write in the same cycle as a bank change lands in the new mode's view. The old bank keeps the value that was live before that edge.
- R9: Both read ports are combinational. Index 15 returns the external program counter input, and writes to index 15 have no effect.
- R10: A saved-status write updates the active word one edge later. If it comes in the same cycle as a bank change, it targets the new bank.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_req | input | 1 | Mode-change request strobe |
| mode_new | input | 5 | Requested mode code |
| mode_out | output | 5 | Current mode code |
| rd_a_idx | input | 4 | Read port A register index |
| rd_a_data | output | 32 | Read port A data |
| rd_b_idx | input | 4 | Read port B register index |
| rd_b_data | output | 32 | Read port B data |
| wr_en | input | 1 | Register write enable |
| wr_idx | input | 4 | Register write index |
| wr_data | input | 32 | Register write data |
| psr_wr_en | input | 1 | Saved status write enable |
| psr_wr_data | input | 32 | Saved status write data |
| pc_in | input | 32 | Program counter returned for index 15 |
| spsr_out | output | 32 | Active saved status word |

## Verification
A corrupted bank copy stays hidden until the mode that owns it is entered again. The bench therefore runs mode round trips, and the wrong register 13, 14 or 8 to 12 value, or the wrong saved status, appears on the read ports in the cycle after the return edge. A swap that fires on a same-mode or same-bank request shows up at once, because a value written since the last real change is replaced by a stale copy. A same-cycle write that lands in the old view shows up both immediately and after the next return to the old mode.

// File: rtl/brf_pkg.sv
package brf_pkg;

  localparam int MODE_W = 5;

  localparam logic [MODE_W-1:0] MD_USR = 5'b10000;
  localparam logic [MODE_W-1:0] MD_FIQ = 5'b10001;
  localparam logic [MODE_W-1:0] MD_IRQ = 5'b10010;
  localparam logic [MODE_W-1:0] MD_SVC = 5'b10011;
  localparam logic [MODE_W-1:0] MD_ABT = 5'b10111;
  localparam logic [MODE_W-1:0] MD_UND = 5'b11011;
  localparam logic [MODE_W-1:0] MD_SYS = 5'b11111;

  typedef enum logic [2:0] {
    BK_NONE = 3'd0,
    BK_FIQ  = 3'd1,
    BK_IRQ  = 3'd2,
    BK_SVC  = 3'd3,
    BK_ABT  = 3'd4,
    BK_UND  = 3'd5
  } bank_e;

  localparam int NUM_BANKS = 6;

  // Unknown codes fall back to the unbanked set.
  function automatic bank_e mode_bank(input logic [MODE_W-1:0] m);
    case (m)
      MD_FIQ:  return BK_FIQ;
      MD_IRQ:  return BK_IRQ;
      MD_SVC:  return BK_SVC;
      MD_ABT:  return BK_ABT;
      MD_UND:  return BK_UND;
      default: return BK_NONE;
    endcase
  endfunction

  function automatic logic is_fiq(input bank_e b);
    return b == BK_FIQ;
  endfunction

endpackage

// File: rtl/brf_mode_ctrl.sv
module brf_mode_ctrl
  import brf_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_req,
  input  logic [MODE_W-1:0] mode_new,
  output logic [MODE_W-1:0] mode_q,
  output bank_e             old_bank,
  output bank_e             new_bank,
  output logic              bank_swap,
  output logic              fiq_swap
);

  logic mode_chg;

  always_comb begin
    old_bank  = mode_bank(mode_q);
    new_bank  = mode_bank(mode_new);
    mode_chg  = mode_req && (mode_new != mode_q);
    bank_swap = mode_chg && (old_bank != new_bank);
    fiq_swap  = bank_swap && (is_fiq(old_bank) || is_fiq(new_bank));
  end

  always_ff @(posedge clk) begin
    if (!rst_n)        mode_q <= MD_SYS;
    else if (mode_chg) mode_q <= mode_new;
  end

endmodule

// File: rtl/brf_bank_store.sv
module brf_bank_store
  import brf_pkg::*;
#(
  parameter int DW      = 32,
  parameter int FIQ_CNT = 5
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  bank_e                         old_bank,
  input  bank_e                         new_bank,
  input  logic                          bank_swap,
  input  logic                          fiq_swap,
  input  logic [DW-1:0]                 live_sp,
  input  logic [DW-1:0]                 live_lr,
  input  logic [DW-1:0]                 live_spsr,
  input  logic [FIQ_CNT-1:0][DW-1:0]    live_hi,
  output logic [DW-1:0]                 load_sp,
  output logic [DW-1:0]                 load_lr,
  output logic [DW-1:0]                 load_spsr,
  output logic [FIQ_CNT-1:0][DW-1:0]    load_hi
);

  logic [DW-1:0]              sp_mem   [NUM_BANKS];
  logic [DW-1:0]              lr_mem   [NUM_BANKS];
  logic [DW-1:0]              spsr_mem [NUM_BANKS];
  // Index 0: copy shared by all modes except fast interrupt; 1: fast interrupt.
  logic [FIQ_CNT-1:0][DW-1:0] hi_mem   [2];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int b = 0; b < NUM_BANKS; b++) begin
        sp_mem[b]   <= '0;
        lr_mem[b]   <= '0;
        spsr_mem[b] <= '0;
      end
      hi_mem[0] <= '0;
      hi_mem[1] <= '0;
    end else begin
      if (bank_swap) begin
        sp_mem[old_bank]   <= live_sp;
        lr_mem[old_bank]   <= live_lr;
        spsr_mem[old_bank] <= live_spsr;
      end
      if (fiq_swap) hi_mem[is_fiq(old_bank)] <= live_hi;
    end
  end

  always_comb begin
    load_sp   = sp_mem[new_bank];
    load_lr   = lr_mem[new_bank];
    load_spsr = spsr_mem[new_bank];
    load_hi   = hi_mem[is_fiq(new_bank)];
  end

endmodule

// File: rtl/brf_live_file.sv
module brf_live_file #(
  parameter int DW       = 32,
  parameter int NUM_REGS = 16,
  parameter int FIQ_LO   = 8,
  parameter int FIQ_CNT  = 5,
  parameter int SP_IDX   = 13,
  parameter int LR_IDX   = 14,
  localparam int IDX_W   = $clog2(NUM_REGS),
  localparam int LIVE_N  = NUM_REGS - 1
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       bank_swap,
  input  logic                       fiq_swap,
  input  logic [DW-1:0]              load_sp,
  input  logic [DW-1:0]              load_lr,
  input  logic [DW-1:0]              load_spsr,
  input  logic [FIQ_CNT-1:0][DW-1:0] load_hi,
  input  logic                       wr_en,
  input  logic [IDX_W-1:0]           wr_idx,
  input  logic [DW-1:0]              wr_data,
  input  logic                       psr_wr_en,
  input  logic [DW-1:0]              psr_wr_data,
  input  logic [IDX_W-1:0]           rd_a_idx,
  input  logic [IDX_W-1:0]           rd_b_idx,
  input  logic [DW-1:0]              pc_in,
  output logic [DW-1:0]              rd_a_data,
  output logic [DW-1:0]              rd_b_data,
  output logic [DW-1:0]              live_sp,
  output logic [DW-1:0]              live_lr,
  output logic [DW-1:0]              spsr_q,
  output logic [FIQ_CNT-1:0][DW-1:0] live_hi
);

  logic [DW-1:0] live_q [LIVE_N];

  function automatic logic [DW-1:0] read_reg(input logic [IDX_W-1:0] idx,
                                             input logic [DW-1:0] pc);
    if (int'(idx) >= LIVE_N) return pc;
    return live_q[idx];
  endfunction

  // The swap loads first; a same-cycle write then overrides, so it hits the new view.
  for (genvar i = 0; i < LIVE_N; i++) begin : g_reg
    logic [DW-1:0] swap_val;
    logic          swap_hit;
    if (i == SP_IDX) begin : g_sp
      assign swap_hit = bank_swap;
      assign swap_val = load_sp;
    end else if (i == LR_IDX) begin : g_lr
      assign swap_hit = bank_swap;
      assign swap_val = load_lr;
    end else if (i >= FIQ_LO && i < FIQ_LO + FIQ_CNT) begin : g_hi
      assign swap_hit = fiq_swap;
      assign swap_val = load_hi[i-FIQ_LO];
      assign live_hi[i-FIQ_LO] = live_q[i];
    end else begin : g_plain
      assign swap_hit = 1'b0;
      assign swap_val = '0;
    end

    always_ff @(posedge clk) begin
      if (!rst_n)                                  live_q[i] <= '0;
      else if (wr_en && int'(wr_idx) == i)         live_q[i] <= wr_data;
      else if (swap_hit)                           live_q[i] <= swap_val;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)         spsr_q <= '0;
    else if (psr_wr_en) spsr_q <= psr_wr_data;
    else if (bank_swap) spsr_q <= load_spsr;
  end

  always_comb begin
    live_sp   = live_q[SP_IDX];
    live_lr   = live_q[LR_IDX];
    rd_a_data = read_reg(rd_a_idx, pc_in);
    rd_b_data = read_reg(rd_b_idx, pc_in);
  end

endmodule

// File: rtl/banked_regfile.sv
module banked_regfile
  import brf_pkg::*;
#(
  parameter int DW       = 32,
  parameter int NUM_REGS = 16,
  parameter int FIQ_LO   = 8,
  parameter int FIQ_CNT  = 5,
  parameter int SP_IDX   = 13,
  parameter int LR_IDX   = 14,
  localparam int IDX_W   = $clog2(NUM_REGS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_req,
  input  logic [MODE_W-1:0] mode_new,
  output logic [MODE_W-1:0] mode_out,
  input  logic [IDX_W-1:0]  rd_a_idx,
  output logic [DW-1:0]     rd_a_data,
  input  logic [IDX_W-1:0]  rd_b_idx,
  output logic [DW-1:0]     rd_b_data,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [DW-1:0]     wr_data,
  input  logic              psr_wr_en,
  input  logic [DW-1:0]     psr_wr_data,
  input  logic [DW-1:0]     pc_in,
  output logic [DW-1:0]     spsr_out
);

  bank_e                      old_bank, new_bank;
  logic                       bank_swap, fiq_swap;
  logic [DW-1:0]              live_sp, live_lr, load_sp, load_lr, load_spsr;
  logic [FIQ_CNT-1:0][DW-1:0] live_hi, load_hi;

  brf_mode_ctrl u_mode (
    .clk, .rst_n, .mode_req, .mode_new,
    .mode_q(mode_out), .old_bank, .new_bank, .bank_swap, .fiq_swap
  );

  brf_bank_store #(.DW(DW), .FIQ_CNT(FIQ_CNT)) u_store (
    .clk, .rst_n, .old_bank, .new_bank, .bank_swap, .fiq_swap,
    .live_sp, .live_lr, .live_spsr(spsr_out), .live_hi,
    .load_sp, .load_lr, .load_spsr, .load_hi
  );

  brf_live_file #(
    .DW(DW), .NUM_REGS(NUM_REGS), .FIQ_LO(FIQ_LO), .FIQ_CNT(FIQ_CNT),
    .SP_IDX(SP_IDX), .LR_IDX(LR_IDX)
  ) u_live (
    .clk, .rst_n, .bank_swap, .fiq_swap,
    .load_sp, .load_lr, .load_spsr, .load_hi,
    .wr_en, .wr_idx, .wr_data, .psr_wr_en, .psr_wr_data,
    .rd_a_idx, .rd_b_idx, .pc_in, .rd_a_data, .rd_b_data,
    .live_sp, .live_lr, .spsr_q(spsr_out), .live_hi
  );

endmodule

// File: rtl/banked_regfile_chk.sv
module banked_regfile_chk
  import brf_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              mode_req,
  input logic [MODE_W-1:0] mode_new,
  input logic [MODE_W-1:0] mode_out,
  input logic              psr_wr_en,
  input logic [31:0]       spsr_out,
  input logic [3:0]        rd_a_idx,
  input logic [31:0]       rd_a_data,
  input logic [31:0]       pc_in,
  input bank_e             old_bank,
  input bank_e             new_bank,
  input logic              bank_swap,
  input logic              fiq_swap
);

  // R3
  same_mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mode_req && mode_new == mode_out && !psr_wr_en |=> $stable(spsr_out) && $stable(mode_out));

  // R4
  mode_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mode_req |=> mode_out == $past(mode_new));

  // R4
  swap_banks_differ_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bank_swap |-> old_bank != new_bank);

  // R5
  fiq_needs_swap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fiq_swap |-> bank_swap);

  // R7
  sys_user_noswap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mode_req && mode_out == MD_SYS && mode_new == MD_USR |-> !bank_swap);

  // R10
  psr_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_req && !psr_wr_en |=> $stable(spsr_out));

  // R9
  pc_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_a_idx == 4'd15 |-> rd_a_data == pc_in);

endmodule

bind banked_regfile banked_regfile_chk u_chk (.*);

// File: tb/test_banked_regfile.sv
module test_banked_regfile;

  localparam int PERIOD = 10;
  localparam logic [2:0] OP_WR = 3'd0, OP_MODE = 3'd1, OP_CHK = 3'd2,
                         OP_PSRW = 3'd3, OP_PSRCHK = 3'd4, OP_MCHK = 3'd5;
  localparam int NV = 38;

  // {op, index or mode, data or expected}
  localparam logic [39:0] VEC [NV] = '{
    {OP_WR,     5'd13,    32'h1000_0013},
    {OP_WR,     5'd14,    32'h1000_0014},
    {OP_WR,     5'd8,     32'h0000_0008},
    {OP_PSRW,   5'd0,     32'h0000_00AA},
    {OP_MODE,   5'b10010, 32'h0},
    {OP_MCHK,   5'd0,     32'h0000_0012},
    {OP_CHK,    5'd13,    32'h0},
    {OP_CHK,    5'd14,    32'h0},
    {OP_CHK,    5'd8,     32'h0000_0008},
    {OP_PSRCHK, 5'd0,     32'h0},
    {OP_WR,     5'd13,    32'h2000_0013},
    {OP_PSRW,   5'd0,     32'h0000_00BB},
    {OP_MODE,   5'b10001, 32'h0},
    {OP_CHK,    5'd8,     32'h0},
    {OP_CHK,    5'd13,    32'h0},
    {OP_WR,     5'd8,     32'h0000_00F8},
    {OP_WR,     5'd12,    32'h0000_00FC},
    {OP_WR,     5'd13,    32'h0000_0F13},
    {OP_MODE,   5'b10011, 32'h0},
    {OP_CHK,    5'd8,     32'h0000_0008},
    {OP_CHK,    5'd12,    32'h0},
    {OP_CHK,    5'd13,    32'h0},
    {OP_MODE,   5'b10010, 32'h0},
    {OP_CHK,    5'd13,    32'h2000_0013},
    {OP_PSRCHK, 5'd0,     32'h0000_00BB},
    {OP_MODE,   5'b10001, 32'h0},
    {OP_CHK,    5'd8,     32'h0000_00F8},
    {OP_CHK,    5'd12,    32'h0000_00FC},
    {OP_CHK,    5'd13,    32'h0000_0F13},
    {OP_MODE,   5'b10000, 32'h0},
    {OP_CHK,    5'd13,    32'h1000_0013},
    {OP_CHK,    5'd14,    32'h1000_0014},
    {OP_CHK,    5'd8,     32'h0000_0008},
    {OP_PSRCHK, 5'd0,     32'h0000_00AA},
    {OP_MODE,   5'b11111, 32'h0},
    {OP_CHK,    5'd13,    32'h1000_0013},
    {OP_MODE,   5'b00101, 32'h0},
    {OP_MCHK,   5'd0,     32'h0000_0005}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        mode_req = 1'b0;
  logic [4:0]  mode_new = '0;
  logic [4:0]  mode_out;
  logic [3:0]  rd_a_idx = '0, rd_b_idx = '0, wr_idx = '0;
  logic [31:0] rd_a_data, rd_b_data, wr_data = '0, psr_wr_data = '0, spsr_out;
  logic        wr_en = 1'b0, psr_wr_en = 1'b0;
  logic [31:0] pc_in = 32'h0800_0100;
  int          n_run = 0, n_fail = 0;

  banked_regfile i_banked_regfile (
    .clk, .rst_n, .mode_req, .mode_new, .mode_out,
    .rd_a_idx, .rd_a_data, .rd_b_idx, .rd_b_data,
    .wr_en, .wr_idx, .wr_data, .psr_wr_en, .psr_wr_data, .pc_in, .spsr_out
  );

  always #(PERIOD/2) clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0; mode_req = 1'b0; psr_wr_en = 1'b0;
  endtask

  function automatic logic [31:0] rd_reg(input logic [3:0] idx);
    rd_a_idx = idx;
    return 32'h0;
  endfunction

  task automatic read_a(input logic [3:0] idx, output logic [31:0] v);
    rd_a_idx = idx;
    #1 v = rd_a_data;
  endtask

  task automatic do_write(input logic [3:0] idx, input logic [31:0] d);
    wr_en = 1'b1; wr_idx = idx; wr_data = d;
  endtask

  task automatic do_mode(input logic [4:0] m);
    mode_req = 1'b1; mode_new = m;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    step(); step();
    rst_n = 1'b1;
  endtask

  initial begin : watchdog
    #(PERIOD*100000);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin : main
    logic [31:0] v;
    @(negedge clk);
    do_reset();

    // R1: reset state
    for (int i = 0; i < 15; i++) begin
      read_a(4'(i), v);
      check("R1 live reg zero", v, 32'h0);
    end
    check("R1 spsr zero", spsr_out, 32'h0);
    check("R1 mode system", {27'h0, mode_out}, 32'h1F);

    // R2 R4 R5 R6 R7: table walk
    for (int k = 0; k < NV; k++) begin
      logic [2:0]  op;
      logic [4:0]  fld;
      logic [31:0] dat;
      {op, fld, dat} = VEC[k];
      case (op)
        OP_WR:     begin do_write(fld[3:0], dat); step(); end
        OP_MODE:   begin do_mode(fld); step(); end
        OP_PSRW:   begin psr_wr_en = 1'b1; psr_wr_data = dat; step(); end
        OP_CHK:    begin read_a(fld[3:0], v); check("R4/R5 table reg", v, dat); end
        OP_PSRCHK: begin #1 check("R6 table spsr", spsr_out, dat); end
        default:   begin #1 check("R2/R7 table mode", {27'h0, mode_out}, dat); end
      endcase
    end

    // R3: same-mode request must not reload stale bank copies
    do_mode(5'b10010); step();
    do_write(4'd13, 32'h3333_0013); psr_wr_en = 1'b1; psr_wr_data = 32'h33; step();
    do_mode(5'b10010); step();
    read_a(4'd13, v);
    check("R3 same-mode keeps sp", v, 32'h3333_0013);
    check("R3 same-mode keeps spsr", spsr_out, 32'h33);
    check("R3 same-mode keeps mode", {27'h0, mode_out}, 32'h12);

    // R8 R10: write and saved-status write in the same cycle as a change
    do_mode(5'b10000); step();
    read_a(4'd13, v);
    check("R4 user sp restored", v, 32'h1000_0013);
    do_mode(5'b10011); do_write(4'd13, 32'hCAFE_0013);
    psr_wr_en = 1'b1; psr_wr_data = 32'h5C; step();
    read_a(4'd13, v);
    check("R8 write lands in new view", v, 32'hCAFE_0013);
    check("R10 psr write lands in new bank", spsr_out, 32'h5C);
    do_mode(5'b10000); step();
    read_a(4'd13, v);
    check("R8 old bank keeps pre-change sp", v, 32'h1000_0013);
    check("R10 old bank spsr intact", spsr_out, 32'hAA);
    do_mode(5'b10011); step();
    read_a(4'd13, v);
    check("R8 new bank kept written sp", v, 32'hCAFE_0013);
    check("R10 new bank kept written spsr", spsr_out, 32'h5C);

    // R9: index 15 and port B
    do_write(4'd15, 32'hDEAD_BEEF); step();
    rd_b_idx = 4'd15; read_a(4'd15, v);
    check("R9 port A pc", v, 32'h0800_0100);
    check("R9 port B pc", rd_b_data, 32'h0800_0100);
    pc_in = 32'h0800_0204; #1;
    check("R9 port B follows pc", rd_b_data, 32'h0800_0204);
    rd_b_idx = 4'd8; #1;
    check("R9 port B reg", rd_b_data, 32'h0000_0008);

    // R1: reset clears banked copies too
    do_reset();
    do_mode(5'b10001); step();
    read_a(4'd8, v);
    check("R1 fiq copy cleared", v, 32'h0);
    read_a(4'd13, v);
    check("R1 banked sp cleared", v, 32'h0);
    check("R1 banked spsr cleared", spsr_out, 32'h0);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule